// File: doc/BRIEF.md
# Read Strobe Latency Calibrator

This block finds, for every byte lane of a read data path, how many controller clock cycles after the read latency expires the first read strobe edge (and so the first data beat) arrives. The skew between strobe and clock spans several cycles and differs between lanes. A fixed capture point therefore cannot serve all lanes. On request, the block issues calibration reads of a known byte. For each read it samples every lane exactly one candidate offset later, trying 2, 3 and 4 cycles in rising order. Each lane keeps the first offset at which its capture matches. A lane that never matches is marked failed.

After calibration, each functional read opens a per-lane capture gate of one burst at that lane's own offset. Per-lane delay registers then re-time the beats so that all lanes present the burst together, one cycle after the latest lane's offset. Calibration can be run again at any time from the ready state, so that drift can be tracked at run time. A per-lane mode chooses between matching bit 0 of the lane only, which is the bit that always carries calibration data, and matching all eight bits.

The sequencer states are IDLE (never calibrated), ISSUE (calibration read pulse), WAIT (count to the candidate), CHECK (compare lanes), DRAIN (let the burst settle) and READY. The transitions are:
- IDLE→ISSUE and READY→ISSUE on a start request.
- ISSUE→WAIT always.
- WAIT→CHECK when the count reaches the candidate.
- CHECK→READY when every lane has locked or the last candidate was checked.
- CHECK→DRAIN otherwise.
- DRAIN→ISSUE after 16 cycles, with the next candidate.

Top module: `rdqs_lat_cal`

## Requirements
- R1: After reset `cal_busy`, `cal_rd`, `gate_en`, `rd_valid` and `lane_fail` are all 0, and every 3-bit field of `lane_off` (lane l at bits 3l+2..3l) reads 4.
- R2: A `cal_start` high in cycle s, while idle or ready, makes `cal_busy` high from cycle s+1, and the first single-cycle `cal_rd` pulse occurs in cycle s+1. The k-th pulse (k from 0) tests candidate 2+k. For a pulse in cycle t with candidate c, each lane is sampled in cycle t+c.
- R3: A lane locks the smallest candidate at which `cap_valid` is high and its data match; later matches of that calibration are ignored.
- R4: With `match_all[l]`=1 all eight bits of the lane must equal `cal_pattern`; with 0 only bit 0 of the lane is compared.
- R5: A lane that matches at none of the candidates 2, 3, 4 gets `lane_fail[l]`=1 and offset 4.
- R6: After each compare that does not end calibration, the next `cal_rd` pulse follows c+17 cycles after the previous pulse (16 drain cycles). Calibration ends after the compare at which all lanes are locked, or after candidate 4, and `cal_busy` then falls.
- R7: In the ready state, `rd_start` high in cycle t raises `gate_en[l]` for exactly 8 cycles, t+off_l through t+off_l+7.
- R8: For such a read, `rd_valid` is high in cycles t+M+1+b (b=0..7, M the largest lane offset). In those cycles, byte l of `rd_data` is the byte lane l drove in cycle t+off_l+b.
- R9: `rd_valid` is never high while calibrating or while any lane is failed, and `rd_start` outside the ready state opens no gate.
- R10: A new calibration started from the ready state replaces every lane's offset and failure flag with the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Request a calibration run |
| rd_start | input | 1 | Read latency of a functional read expires this cycle |
| match_all | input | 4 | Per-lane mode: 1 all bits, 0 bit 0 only |
| cal_pattern | input | 8 | Expected calibration byte |
| cap_valid | input | 4 | Per-lane captured beat valid |
| cap_data | input | 32 | Per-lane captured bytes, lane l at bits 8l+7..8l |
| cal_rd | output | 1 | Issue a calibration read (latency expires this cycle) |
| cal_busy | output | 1 | Calibration in progress |
| lane_fail | output | 4 | Lane found no matching offset |
| lane_off | output | 12 | Per-lane chosen offset, 3 bits each |
| gate_en | output | 4 | Per-lane capture gate |
| rd_valid | output | 1 | Aligned burst beat valid |
| rd_data | output | 32 | Aligned burst beat, all lanes |

## Verification
The assertions assume that the capture path returns each calibration burst fully before the next calibration read, and that functional reads are at least one burst apart. They also assume that `rd_start` is not used in the cycles around a calibration start. The stimulus keeps within these limits. Lane strobe delays are at most 7 cycles, so every calibration burst ends inside the 16-cycle drain. Reads are spaced 12 cycles apart. At least 18 cycles pass between the last read and a new calibration.

// File: rtl/rdqs_cal_pkg.sv
package rdqs_cal_pkg;
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_ISSUE,
        CS_WAIT,
        CS_CHECK,
        CS_DRAIN,
        CS_READY
    } cal_state_t;
endpackage

// File: rtl/rdqs_cal_seq.sv
module rdqs_cal_seq
    import rdqs_cal_pkg::*;
#(
    parameter int OFF_MIN = 2,
    parameter int OFF_MAX = 4,
    parameter int BURST   = 8,
    parameter int OW      = $clog2(OFF_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_start,
    input  logic          settle,
    output logic [OW-1:0] cand,
    output logic          cal_rd,
    output logic          chk,
    output logic          clr,
    output logic          fin,
    output logic          ready,
    output logic          busy
);
    localparam int DRAIN_LEN = BURST + 2 * OFF_MAX;
    localparam int DW        = $clog2(DRAIN_LEN);

    cal_state_t    state, nxt;
    logic [OW-1:0] wcnt;
    logic [DW-1:0] dcnt;
    logic          last;

    assign last = settle || (cand == OW'(OFF_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE, CS_READY: if (cal_start) nxt = CS_ISSUE;
            CS_ISSUE:          nxt = CS_WAIT;
            CS_WAIT:           if (wcnt == OW'(1)) nxt = CS_CHECK;
            CS_CHECK:          nxt = last ? CS_READY : CS_DRAIN;
            CS_DRAIN:          if (dcnt == '0) nxt = CS_ISSUE;
            default:           nxt = CS_IDLE;
        endcase
    end

    // candidate, wait and drain counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= OW'(OFF_MIN);
            wcnt <= '0;
            dcnt <= '0;
        end else begin
            unique case (state)
                CS_IDLE, CS_READY: if (cal_start) cand <= OW'(OFF_MIN);
                CS_ISSUE: wcnt <= cand - OW'(1);
                CS_WAIT:  wcnt <= wcnt - OW'(1);
                CS_CHECK: begin
                    dcnt <= DW'(DRAIN_LEN - 1);
                    if (!last) cand <= cand + OW'(1);
                end
                CS_DRAIN: dcnt <= dcnt - DW'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        cal_rd = (state == CS_ISSUE);
        chk    = (state == CS_CHECK);
        fin    = (state == CS_CHECK) && last;
        ready  = (state == CS_READY);
        busy   = (state != CS_IDLE) && (state != CS_READY);
        clr    = ((state == CS_IDLE) || (state == CS_READY)) && cal_start;
    end
endmodule

// File: rtl/rdqs_cal_lane.sv
module rdqs_cal_lane #(
    parameter int LANE_W  = 8,
    parameter int OFF_MIN = 2,
    parameter int OFF_MAX = 4,
    parameter int BURST   = 8,
    parameter int OW      = $clog2(OFF_MAX + 1),
    parameter int HW      = 1 << OW,
    parameter int TW      = $clog2(OFF_MAX - OFF_MIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_all,
    input  logic [LANE_W-1:0] pat,
    input  logic              cap_valid,
    input  logic [LANE_W-1:0] cap_data,
    input  logic              clr,
    input  logic              chk,
    input  logic              fin,
    input  logic [OW-1:0]     cand,
    input  logic              go,
    input  logic [HW-1:0]     hist,
    input  logic [TW-1:0]     tap_sel,
    output logic              hit,
    output logic              locked,
    output logic              fail,
    output logic [OW-1:0]     off,
    output logic              gate_en,
    output logic              tap_v,
    output logic [LANE_W-1:0] tap_d
);
    localparam int CW   = $clog2(BURST);
    localparam int SR_N = 1 << TW;

    logic              match, start;
    logic [CW-1:0]     cnt;
    logic [LANE_W:0]   sr [SR_N];

    assign match = cap_valid && (match_all ? (cap_data == pat) : (cap_data[0] == pat[0]));
    assign hit   = chk && !locked && match;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            locked <= 1'b0;
            fail   <= 1'b0;
            off    <= OW'(OFF_MAX);
        end else if (hit) begin
            locked <= 1'b1;
            off    <= cand;
        end else if (fin && !locked) begin
            fail   <= 1'b1;
        end
    end

    // gate window of one burst starting off cycles after the read
    assign start   = hist[off - OW'(1)];
    assign gate_en = go && (start || (cnt != '0));

    always_ff @(posedge clk) begin
        if (!rst_n || !go)   cnt <= '0;
        else if (start)      cnt <= CW'(BURST - 1);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    // deskew delay line
    always_ff @(posedge clk) begin
        if (!rst_n) sr[0] <= '0;
        else        sr[0] <= {gate_en && cap_valid, cap_data};
    end

    for (genvar i = 1; i < SR_N; i++) begin : g_sr
        always_ff @(posedge clk) begin
            if (!rst_n) sr[i] <= '0;
            else        sr[i] <= sr[i-1];
        end
    end

    assign tap_v = sr[tap_sel][LANE_W];
    assign tap_d = sr[tap_sel][LANE_W-1:0];
endmodule

// File: rtl/rdqs_lat_cal.sv
module rdqs_lat_cal #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8,
    parameter int OFF_MIN   = 2,
    parameter int OFF_MAX   = 4,
    parameter int BURST     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cal_start,
    input  logic                          rd_start,
    input  logic [NUM_LANES-1:0]          match_all,
    input  logic [LANE_W-1:0]             cal_pattern,
    input  logic [NUM_LANES-1:0]          cap_valid,
    input  logic [NUM_LANES*LANE_W-1:0]   cap_data,
    output logic                          cal_rd,
    output logic                          cal_busy,
    output logic [NUM_LANES-1:0]          lane_fail,
    output logic [NUM_LANES*$clog2(OFF_MAX+1)-1:0] lane_off,
    output logic [NUM_LANES-1:0]          gate_en,
    output logic                          rd_valid,
    output logic [NUM_LANES*LANE_W-1:0]   rd_data
);
    localparam int OW = $clog2(OFF_MAX + 1);
    localparam int HW = 1 << OW;
    localparam int TW = $clog2(OFF_MAX - OFF_MIN + 1);

    logic [OW-1:0]          cand, max_off;
    logic                   chk, clr, fin, ready, settle;
    logic [HW-1:0]          hist;
    logic [NUM_LANES-1:0]   hit, locked, tap_v;
    logic [OW-1:0]          off [NUM_LANES];
    logic [TW-1:0]          tap_sel [NUM_LANES];

    rdqs_cal_seq #(.OFF_MIN(OFF_MIN), .OFF_MAX(OFF_MAX), .BURST(BURST), .OW(OW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .settle(settle),
        .cand(cand), .cal_rd(cal_rd), .chk(chk), .clr(clr), .fin(fin),
        .ready(ready), .busy(cal_busy)
    );

    assign settle = &(locked | hit);

    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HW-2:0], rd_start && ready};
    end

    always_comb begin
        max_off = OW'(OFF_MIN);
        for (int l = 0; l < NUM_LANES; l++)
            if (off[l] > max_off) max_off = off[l];
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign tap_sel[l] = TW'(max_off - off[l]);
        assign lane_off[l*OW +: OW] = off[l];

        rdqs_cal_lane #(
            .LANE_W(LANE_W), .OFF_MIN(OFF_MIN), .OFF_MAX(OFF_MAX),
            .BURST(BURST), .OW(OW), .HW(HW), .TW(TW)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .match_all(match_all[l]), .pat(cal_pattern),
            .cap_valid(cap_valid[l]), .cap_data(cap_data[l*LANE_W +: LANE_W]),
            .clr(clr), .chk(chk), .fin(fin), .cand(cand), .go(ready),
            .hist(hist), .tap_sel(tap_sel[l]), .hit(hit[l]), .locked(locked[l]),
            .fail(lane_fail[l]), .off(off[l]), .gate_en(gate_en[l]),
            .tap_v(tap_v[l]), .tap_d(rd_data[l*LANE_W +: LANE_W])
        );
    end

    assign rd_valid = ready && !(|lane_fail) && (&tap_v);
endmodule

// File: rtl/rdqs_cal_chk.sv
module rdqs_cal_chk #(
    parameter int NUM_LANES = 4,
    parameter int OFF_MIN   = 2,
    parameter int OFF_MAX   = 4,
    parameter int OW        = $clog2(OFF_MAX + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cal_rd,
    input logic                    cal_busy,
    input logic                    rd_valid,
    input logic [NUM_LANES-1:0]    gate_en,
    input logic [NUM_LANES-1:0]    lane_fail,
    input logic [NUM_LANES*OW-1:0] lane_off
);
    AST_CAL_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cal_rd |=> !cal_rd); // R2
    AST_CAL_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cal_rd |-> cal_busy); // R2
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cal_busy |-> (!rd_valid && gate_en == '0)); // R9
    AST_NO_VALID_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (|lane_fail) |-> !rd_valid); // R9

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_off[l*OW +: OW] >= OW'(OFF_MIN)) && (lane_off[l*OW +: OW] <= OW'(OFF_MAX))); // R3
        AST_FAIL_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            lane_fail[l] |-> (lane_off[l*OW +: OW] == OW'(OFF_MAX))); // R5
    end
endmodule

bind rdqs_lat_cal rdqs_cal_chk #(
    .NUM_LANES(NUM_LANES), .OFF_MIN(OFF_MIN), .OFF_MAX(OFF_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_rd(cal_rd), .cal_busy(cal_busy),
    .rd_valid(rd_valid), .gate_en(gate_en), .lane_fail(lane_fail),
    .lane_off(lane_off)
);

// File: tb/tb_rdqs_lat_cal.sv
module tb_rdqs_lat_cal;
    localparam int NL = 4;
    localparam logic [7:0] PAT = 8'hA5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cal_start = 1'b0, rd_start = 1'b0;
    logic [3:0]  match_all = 4'hF;
    logic [7:0]  cal_pattern = PAT;
    logic [3:0]  cap_valid = '0;
    logic [31:0] cap_data = {4{~PAT}};
    logic        cal_rd, cal_busy, rd_valid;
    logic [3:0]  lane_fail, gate_en;
    logic [11:0] lane_off;
    logic [31:0] rd_data;

    rdqs_lat_cal dut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit [3:0]  eg [int];
    bit        ev [int];
    bit [31:0] ed [int];
    bit [3:0]  sv [int];
    bit [31:0] sd [int];

    int tru [NL];
    logic [7:0] cdat [NL];
    int  exp_off [NL];
    bit [3:0] exp_fail = '0;
    bit  model_ready = 0;
    int  start_cyc = 0, npulse = 0, last_pulse = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void put_lane(int c, int l, logic [7:0] v);
        bit [3:0] tv; bit [31:0] td;
        if (!sv.exists(c)) begin sv[c] = '0; sd[c] = {4{~PAT}}; end
        tv = sv[c]; td = sd[c];
        tv[l] = 1'b1; td[l*8 +: 8] = v;
        sv[c] = tv; sd[c] = td;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // per-cycle comparison and lane capture model
    always @(negedge clk) begin
        bit [3:0] xg; bit xv;
        xg = eg.exists(cyc) ? eg[cyc] : 4'h0;
        xv = ev.exists(cyc) ? ev[cyc] : 1'b0;
        chk(gate_en == xg, "R7 gate_en", gate_en, xg);
        chk(rd_valid == xv, "R8/R9 rd_valid", rd_valid, xv);
        if (xv) chk(rd_data == ed[cyc], "R8 rd_data", rd_data, ed[cyc]);
        if (cal_rd) begin
            if (npulse == 0) chk(cyc == start_cyc + 1, "R2 first cal_rd cycle", cyc, start_cyc + 1);
            else chk(cyc - last_pulse == (1 + npulse) + 17, "R6 cal_rd interval",
                     cyc - last_pulse, (1 + npulse) + 17);
            last_pulse = cyc;
            npulse++;
            for (int l = 0; l < NL; l++)
                for (int b = 0; b < 8; b++) put_lane(cyc + tru[l] + b, l, cdat[l]);
        end
        cap_valid = sv.exists(cyc) ? sv[cyc] : 4'h0;
        cap_data  = sd.exists(cyc) ? sd[cyc] : {4{~PAT}};
    end

    task automatic run_cal(input string tag);
        int mx, nexp;
        bit ok;
        mx = 0;
        for (int l = 0; l < NL; l++) begin
            ok = match_all[l] ? (cdat[l] == PAT) : (cdat[l][0] == PAT[0]);
            if (ok && tru[l] <= 4) begin
                exp_off[l] = (tru[l] < 2) ? 2 : tru[l];
                exp_fail[l] = 1'b0;
            end else begin
                exp_off[l] = 4;
                exp_fail[l] = 1'b1;
            end
            if (exp_off[l] > mx) mx = exp_off[l];
        end
        nexp = (exp_fail != 0) ? 3 : mx - 1;
        model_ready = 0;
        @(negedge clk); #1;
        cal_start = 1'b1; start_cyc = cyc; npulse = 0;
        @(negedge clk); #1;
        cal_start = 1'b0;
        chk(cal_busy == 1'b1, "R2 busy after start", cal_busy, 1);
        while (cal_busy) @(negedge clk);
        #1;
        chk(npulse == nexp, "R6 calibration read count", npulse, nexp);
        for (int l = 0; l < NL; l++)
            chk(lane_off[l*3 +: 3] == 3'(exp_off[l]), {tag, " R3/R4 lane offset"},
                lane_off[l*3 +: 3], exp_off[l]);
        chk(lane_fail == exp_fail, {tag, " R4/R5 lane_fail"}, lane_fail, exp_fail);
        model_ready = 1;
        repeat (20) @(negedge clk);
    endtask

    task automatic do_read(input int rn);
        int t, mx;
        bit [31:0] td;
        @(negedge clk); #1;
        rd_start = 1'b1; t = cyc;
        if (model_ready) begin
            mx = 0;
            for (int l = 0; l < NL; l++) if (exp_off[l] > mx) mx = exp_off[l];
            for (int l = 0; l < NL; l++)
                for (int b = 0; b < 8; b++) begin
                    logic [7:0] v;
                    v = 8'(16 * l + b + 3 * rn + 1);
                    eg[t + exp_off[l] + b] = eg.exists(t + exp_off[l] + b)
                                             ? (eg[t + exp_off[l] + b] | (4'h1 << l)) : (4'h1 << l);
                    if (exp_fail == 0) begin
                        put_lane(t + tru[l] + b, l, v);
                        ev[t + mx + 1 + b] = 1'b1;
                        td = ed.exists(t + mx + 1 + b) ? ed[t + mx + 1 + b] : 32'h0;
                        td[l*8 +: 8] = v;
                        ed[t + mx + 1 + b] = td;
                    end
                end
        end
        @(negedge clk); #1;
        rd_start = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin tru[l] = 2; cdat[l] = PAT; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(cal_busy == 0 && cal_rd == 0, "R1 busy/cal_rd", {cal_busy, cal_rd}, 0);
        chk(gate_en == 0 && rd_valid == 0, "R1 gate/valid", {gate_en, rd_valid}, 0);
        chk(lane_fail == 0, "R1 lane_fail", lane_fail, 0);
        chk(lane_off == {4{3'd4}}, "R1 lane_off", lane_off, {4{3'd4}});
        // R9: reads before calibration open nothing
        do_read(0);
        chk(gate_en == 0 && rd_valid == 0, "R9 idle read ignored", {gate_en, rd_valid}, 0);

        // mixed offsets, all-bit mode; lane 0 matches at 2, 3 and 4 and keeps 2 (R3)
        tru[0] = 2; tru[1] = 3; tru[2] = 4; tru[3] = 2;
        match_all = 4'hF;
        run_cal("calA");
        for (int r = 1; r <= 4; r++) do_read(r);
        repeat (8) @(negedge clk);

        // bit-0 mode lane passes, all-bit lane fails, late lane fails (R4, R5, R9)
        tru[0] = 3; tru[1] = 2; tru[2] = 2; tru[3] = 7;
        cdat[1] = PAT ^ 8'hFE; cdat[2] = PAT ^ 8'hFE;
        match_all = 4'b1101;
        run_cal("calB");
        for (int r = 5; r <= 6; r++) do_read(r);
        chk(rd_valid == 0, "R9 no valid with failed lane", rd_valid, 0);
        repeat (8) @(negedge clk);

        // run-time recalibration replaces all results (R10)
        tru[0] = 4; tru[1] = 2; tru[2] = 2; tru[3] = 3;
        cdat[1] = PAT; cdat[2] = PAT;
        match_all = 4'hF;
        run_cal("R10 recal");
        for (int r = 7; r <= 10; r++) do_read(r);
        repeat (8) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule